// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block expands one decoded multi-register load or store instruction into a stream of simple micro-operations, one per accepted cycle. It latches a 16-bit register list, a base register index and four mode bits. `pre` chooses whether the address is incremented before the access. `up` sets the direction. `wb` requests base writeback. `ld` selects a load rather than a store.

The block first emits a copy of the base register into a scratch register. It then emits one transfer per selected register, lowest index first. Each transfer carries an offset magnitude and an add/subtract bit that are applied to the scratch copy. When writeback is requested, a final base update follows. The downstream pipeline takes micro-ops through a valid/ready handshake. `busy` is high from acceptance until the last micro-op has been taken.

The controller has four named states. `IDLE` waits for an instruction. `COPY` presents the base copy. `XFER` presents transfers. `WBACK` presents the base update. The transitions are as follows. `IDLE→COPY` happens on acceptance. `COPY→XFER` happens when the list is non-empty. `COPY→WBACK` happens when the list is empty and writeback is requested. `COPY→IDLE` happens when the list is empty and there is no writeback. `XFER→XFER` happens while registers remain. `XFER→WBACK` and `XFER→IDLE` happen after the last register, depending on `wb`. `WBACK→IDLE` happens when the update is taken. A state only advances when a micro-op is taken.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset `in_ready` is 1, and `busy` and `uop_valid` are 0.
- R2: An instruction is accepted only when `in_ready` is 1. `in_ready` is 1 only in `IDLE`. Instructions offered while busy leave the emitted sequence unchanged.
- R3: The first micro-op after acceptance is a copy (opcode 0). It has `uop_reg` = 16 (scratch), `uop_base` = the base index, offset 0 and `uop_add` = 1.
- R4: With N set bits in the list, exactly N transfers follow. They name the set registers in ascending index order and use `uop_base` = 16. The opcode is 1 (load) when `ld` is 1 and 2 (store) otherwise.
- R5: The first transfer's offset is 0 when `up` is 1, or 4·N−4 when `up` is 0. A further 4 is added to either value when `pre` is 1.
- R6: Each later transfer's offset is the previous one plus 4 when `up` is 1, or minus 4 when `up` is 0. `uop_add` equals `up` on every transfer.
- R7: When `wb` is 1, a final micro-op follows the transfers. Its `uop_reg` and `uop_base` both equal the base index and its offset is 4·N. The opcode is 3 with `uop_add` = 1 when `up` is 1, or 4 with `uop_add` = 0 when `up` is 0.
- R8: `uop_last` is 1 on exactly the final micro-op of each sequence. `busy` falls in the cycle after that micro-op is taken.
- R9: An empty list yields only the copy, or the copy followed by the base update when `wb` is 1.
- R10: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted this cycle if valid |
| in_list | input | 16 | Register selection mask |
| in_base | input | 4 | Base register index |
| in_pre | input | 1 | Step offset before access |
| in_up | input | 1 | Ascending direction |
| in_wb | input | 1 | Write back base register |
| in_ld | input | 1 | Load (1) or store (0) |
| busy | output | 1 | Sequence in progress |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Downstream takes micro-op |
| uop_opc | output | 3 | 0 copy, 1 load, 2 store, 3 add-immediate, 4 subtract-immediate |
| uop_reg | output | 5 | Destination or transfer register (16 = scratch) |
| uop_base | output | 5 | Base operand register |
| uop_off | output | 12 | Offset magnitude |
| uop_add | output | 1 | 1 add offset, 0 subtract |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
Two events can fall in the same cycle. The first is the handshake that takes the final micro-op, when the state falls back to `IDLE`. The second is a fresh instruction offered while the sequencer is still busy. The bench keeps `in_valid` asserted with unrelated fields on random cycles throughout every sequence, including the final handshake. It then checks that `in_ready` stayed low, that the emitted micro-ops matched the arithmetic model of the original instruction, and that `busy` was low with nothing pending on the next cycle. Random back-pressure makes the final handshake land on varying cycles. The sweep covers all sixteen mode combinations against a set of register lists that includes empty, single, full and sparse masks.

// File: rtl/lsm_uop_pkg.sv
package lsm_uop_pkg;
    typedef enum logic [2:0] {
        OP_MOV  = 3'd0,
        OP_LDR  = 3'd1,
        OP_STR  = 3'd2,
        OP_ADDI = 3'd3,
        OP_SUBI = 3'd4
    } uop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_XFER,
        ST_WBACK
    } seq_state_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int W   = 16,
    parameter int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_uop_pkg::*;
#(
    parameter int LIST_W = 16,
    parameter int OFF_W  = 12,
    parameter int STEP   = 4,
    parameter int IDX_W  = $clog2(LIST_W),
    parameter int RIDX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LIST_W-1:0] in_list,
    input  logic [IDX_W-1:0]  in_base,
    input  logic              in_pre,
    input  logic              in_up,
    input  logic              in_wb,
    input  logic              in_ld,
    output logic              busy,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [2:0]        uop_opc,
    output logic [RIDX_W-1:0] uop_reg,
    output logic [RIDX_W-1:0] uop_base,
    output logic [OFF_W-1:0]  uop_off,
    output logic              uop_add,
    output logic              uop_last
);
    localparam int CNT_W = $clog2(LIST_W + 1);
    localparam logic [RIDX_W-1:0] SCRATCH_IDX = RIDX_W'(LIST_W);
    localparam logic [OFF_W-1:0]  STEP_V      = OFF_W'(STEP);

    seq_state_e        state_q, state_d;
    logic [LIST_W-1:0] work_q;
    logic [IDX_W-1:0]  base_q;
    logic              up_q, wb_q, ld_q;
    logic [CNT_W-1:0]  n_q, left_q;
    logic [OFF_W-1:0]  off_q;

    logic [CNT_W-1:0]  in_cnt;
    logic [IDX_W-1:0]  low_idx;
    logic [OFF_W-1:0]  start_off;
    logic [OFF_W-1:0]  span;
    logic              accept, fire;
    uop_op_e           opc_e;

    lsm_popcnt #(.W(LIST_W), .CW(CNT_W)) u_cnt (.vec(in_list), .cnt(in_cnt));
    lsm_lowbit #(.W(LIST_W), .IW(IDX_W)) u_low (.vec(work_q), .idx(low_idx));

    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign uop_valid = busy;
    assign accept    = in_valid && in_ready;
    assign fire      = uop_valid && uop_ready;
    assign span      = OFF_W'(n_q) * STEP_V;

    // Start offset: ascending begins at zero, descending at the top slot;
    // pre-stepping shifts either by one slot.
    always_comb begin
        if (in_up) start_off = '0;
        else       start_off = OFF_W'(in_cnt) * STEP_V - STEP_V;
        if (in_pre) start_off = start_off + STEP_V;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_COPY;
            ST_COPY:  if (fire) begin
                          if (n_q != '0) state_d = ST_XFER;
                          else if (wb_q) state_d = ST_WBACK;
                          else           state_d = ST_IDLE;
                      end
            ST_XFER:  if (fire && left_q == CNT_W'(1)) begin
                          state_d = wb_q ? ST_WBACK : ST_IDLE;
                      end
            ST_WBACK: if (fire) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Instruction context and walking list
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            base_q <= '0;
            up_q   <= 1'b0;
            wb_q   <= 1'b0;
            ld_q   <= 1'b0;
            n_q    <= '0;
            left_q <= '0;
            off_q  <= '0;
        end else if (accept) begin
            work_q <= in_list;
            base_q <= in_base;
            up_q   <= in_up;
            wb_q   <= in_wb;
            ld_q   <= in_ld;
            n_q    <= in_cnt;
            left_q <= in_cnt;
            off_q  <= start_off;
        end else if (fire && state_q == ST_XFER) begin
            work_q <= work_q & ~(LIST_W'(1) << low_idx);
            left_q <= left_q - CNT_W'(1);
            off_q  <= up_q ? off_q + STEP_V : off_q - STEP_V;
        end
    end

    // Micro-op outputs
    always_comb begin
        opc_e    = OP_MOV;
        uop_reg  = '0;
        uop_base = '0;
        uop_off  = '0;
        uop_add  = 1'b1;
        uop_last = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COPY: begin
                uop_reg  = SCRATCH_IDX;
                uop_base = {1'b0, base_q};
                uop_last = (n_q == '0) && !wb_q;
            end
            ST_XFER: begin
                opc_e    = ld_q ? OP_LDR : OP_STR;
                uop_reg  = {1'b0, low_idx};
                uop_base = SCRATCH_IDX;
                uop_off  = off_q;
                uop_add  = up_q;
                uop_last = (left_q == CNT_W'(1)) && !wb_q;
            end
            ST_WBACK: begin
                opc_e    = up_q ? OP_ADDI : OP_SUBI;
                uop_reg  = {1'b0, base_q};
                uop_base = {1'b0, base_q};
                uop_off  = span;
                uop_add  = up_q;
                uop_last = 1'b1;
            end
            default: ;
        endcase
        uop_opc = opc_e;
    end

    // Stalled micro-op holds
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_opc) && $stable(uop_reg)
            && $stable(uop_base) && $stable(uop_off) && $stable(uop_add) && $stable(uop_last)));

    // Acceptance is followed by the base copy
    assert_copy_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (uop_valid && uop_opc == 3'd0 && uop_reg == SCRATCH_IDX));

    // Taking the last micro-op ends the sequence
    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> (!busy && in_ready));

    // Consecutive transfers step by one slot in the add/subtract direction
    assert_offset_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uop_valid && uop_ready && (uop_opc == 3'd1 || uop_opc == 3'd2))
         && uop_valid && (uop_opc == 3'd1 || uop_opc == 3'd2))
        |-> (uop_off == (uop_add ? $past(uop_off) + STEP_V : $past(uop_off) - STEP_V)));

    // Base update always closes the sequence
    assert_wb_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_opc == 3'd3 || uop_opc == 3'd4)) |-> uop_last);
endmodule

// File: tb/lsm_uop_seq_tb_top.sv
module lsm_uop_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_list = '0;
    logic [3:0]  in_base = '0;
    logic        in_pre = 1'b0, in_up = 1'b0, in_wb = 1'b0, in_ld = 1'b0;
    logic        busy, uop_valid;
    logic        uop_ready = 1'b0;
    logic [2:0]  uop_opc;
    logic [4:0]  uop_reg, uop_base;
    logic [11:0] uop_off;
    logic        uop_add, uop_last;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] lfsr = 8'hA7;

    always #5 clk = ~clk;

    lsm_uop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_list(in_list), .in_base(in_base), .in_pre(in_pre), .in_up(in_up),
        .in_wb(in_wb), .in_ld(in_ld), .busy(busy), .uop_valid(uop_valid),
        .uop_ready(uop_ready), .uop_opc(uop_opc), .uop_reg(uop_reg),
        .uop_base(uop_base), .uop_off(uop_off), .uop_add(uop_add), .uop_last(uop_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    function automatic int nth_set(input logic [15:0] lst, input int j);
        int c = 0;
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                if (c == j) return i;
                c++;
            end
        end
        return -1;
    endfunction

    function automatic logic [15:0] list_of(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            3: return 16'hFFFF;
            4: return 16'h00A5;
            5: return 16'h5A00;
            6: return 16'h8001;
            default: return 16'h0010;
        endcase
    endfunction

    task automatic run_seq(input logic [15:0] lst, input logic [3:0] b,
                           input logic p, input logic u, input logic w, input logic l);
        int n = $countones(lst);
        int total = 1 + n + (w ? 1 : 0);
        int k = 0;
        bit stalled = 0;
        logic [26:0] prev = '0;
        @(negedge clk);
        chk(in_ready && !busy, "R2 idle before accept", int'(in_ready), 1);
        in_valid = 1'b1; in_list = lst; in_base = b;
        in_pre = p; in_up = u; in_wb = w; in_ld = l;
        @(posedge clk);
        while (k < total) begin
            @(negedge clk);
            step_lfsr();
            // Offer an unrelated instruction while busy
            in_valid = lfsr[2]; in_list = ~lst ^ {8{lfsr[7:6]}};
            in_base = ~b; in_up = ~u; in_wb = ~w; in_ld = ~l; in_pre = ~p;
            chk(!in_ready && busy, "R2 not ready while busy", int'(in_ready), 0);
            chk(uop_valid, "R8 valid until last taken", int'(uop_valid), 1);
            if (stalled)
                chk({uop_opc, uop_reg, uop_base, uop_off, uop_add, uop_last} == prev,
                    "R10 hold under stall",
                    int'({uop_opc, uop_reg, uop_base, uop_off, uop_add, uop_last}), int'(prev));
            if (k == 0) begin
                chk(uop_opc == 3'd0 && uop_reg == 5'd16 && uop_base == {1'b0, b}
                    && uop_off == 0 && uop_add, "R3 base copy", int'(uop_opc), 0);
            end else if (k <= n) begin
                int j = k - 1;
                int exp_off = (u ? 0 : 4 * n - 4) + (p ? 4 : 0) + (u ? 4 * j : -4 * j);
                chk(uop_opc == (l ? 3'd1 : 3'd2), "R4 transfer opcode", int'(uop_opc), l ? 1 : 2);
                chk(int'(uop_reg) == nth_set(lst, j), "R4 ascending register",
                    int'(uop_reg), nth_set(lst, j));
                chk(uop_base == 5'd16, "R4 scratch base", int'(uop_base), 16);
                chk(int'(uop_off) == exp_off, j == 0 ? "R5 start offset" : "R6 offset step",
                    int'(uop_off), exp_off);
                chk(uop_add == u, "R6 direction bit", int'(uop_add), int'(u));
            end else begin
                chk(uop_opc == (u ? 3'd3 : 3'd4) && uop_add == u, "R7 writeback op",
                    int'(uop_opc), u ? 3 : 4);
                chk(uop_reg == {1'b0, b} && uop_base == {1'b0, b}, "R7 writeback reg",
                    int'(uop_reg), int'(b));
                chk(int'(uop_off) == 4 * n, "R7 writeback amount", int'(uop_off), 4 * n);
                if (n == 0) chk(1'b1, "R9 empty list with writeback", 0, 0);
            end
            chk(uop_last == (k == total - 1), "R8 last flag", int'(uop_last),
                int'(k == total - 1));
            prev = {uop_opc, uop_reg, uop_base, uop_off, uop_add, uop_last};
            uop_ready = lfsr[0] | lfsr[1];
            stalled = !uop_ready;
            @(posedge clk);
            if (uop_ready) k++;
        end
        @(negedge clk);
        in_valid = 1'b0; uop_ready = 1'b0;
        chk(!busy && !uop_valid && in_ready, "R8 idle after last", int'(busy), 0);
        if (n == 0 && !w) chk(total == 1, "R9 empty list copy only", total, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !busy && !uop_valid, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !busy && !uop_valid, "R1 after release", int'(uop_valid), 0);
        for (int li = 0; li < 8; li++) begin
            for (int m = 0; m < 16; m++) begin
                run_seq(list_of(li), 4'(li * 3 + m), m[0], m[1], m[2], m[3]);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule